// File: doc/BRIEF.md
# Column-Wise Toffoli Cascade Multiplier

This block is a bit-level model of an unsigned N-by-N multiplier. It is built only from multi-control Toffoli gates, each of which flips one target line when all of its control lines are 1. The product is split into 2N columns, and each column is a single block. Every partial product in a column, and every extra carry that reaches it, adds one to the column's counter through a cascade of Toffoli gates. A cascade starts with its widest gate and ends with its narrowest. Bit 0 of the counter is the product bit. The higher bits are carry lines, and the counter bit of weight 2^k goes to column c+k.

A column's sum line is its first incoming carry line (from the nearest earlier column), or a fresh zero ancilla when no carry arrives. Each higher counter bit uses a fresh zero ancilla. Operand lines are only ever controls, so they pass through in place of fan-out. All lines form one vector: a at [N-1:0], b at [2N-1:N], and ancillas above that. The gate list is worked out when the design is elaborated and is evaluated combinationally. A mode input runs the same list in reverse order, which recovers the original lines from a forward result.

Top module: `tof_col_multiplier`

## Requirements
- R1: While rst_n is low at a rising clock edge, line_out and product become all zero at that edge, whatever line_in carries.
- R2: line_out and product reflect line_in and run_backward as sampled at the previous rising edge (one register stage), and hold until the next edge.
- R3: In forward mode (run_backward=0), with a on lines [N-1:0], b on lines [2N-1:N] and every ancilla line zero, product equals a*b as an unsigned 2N-bit value, for N = 2, 4 and 8.
- R4: Lines [2N-1:0] of line_out equal lines [2N-1:0] of the sampled line_in in both modes.
- R5: With run_backward=1, feeding a forward line_out back in returns the original lines: the operands, and every ancilla at zero.
- R6: In forward mode with zero ancillas and a=0 or b=0, every ancilla line of line_out stays zero.
- R7: The line vector is 8 lines wide for N=2 and 20 lines wide for N=4. This follows from one fresh ancilla per counter bit, except where an incoming carry serves as bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_backward | input | 1 | 1 applies the gate list in reverse order |
| line_in | input | NL | All lines: a, b, then ancillas |
| line_out | output | NL | All lines after the cascade, registered |
| product | output | 2N | Sum lines of columns 0..2N-1, meaningful in forward mode |

## Verification
On every cycle, the assertions check four things: the pass-through of the operand lines, the product against a*b for any forward input with clean ancillas, the all-zero ancillas when an operand is zero, and the reset value seen at release. Only the bench's scenarios can show the round trip through reverse mode, since it needs the output of one cycle fed back in the next. The same holds for the exact line count and for the one-cycle hold of the output before the next edge.

// File: rtl/tofmul_pkg.sv
package tofmul_pkg;

    localparam int MAXC = 16;
    localparam int MAXW = 8;
    localparam int MAXL = 256;

    typedef logic [MAXC-1:0][3:0]           wtab_t;
    typedef logic [MAXC-1:0][MAXW-1:0][7:0] ltab_t;

    typedef struct packed {
        logic [15:0]     total;
        logic [7:0]      tgt;
        logic [MAXL-1:0] ctl;
    } gate_t;

    function automatic int bits_for(input int m);
        return (m <= 1) ? 1 : $clog2(m + 1);
    endfunction

    function automatic int pp_count(input int n, input int c);
        return (c < n) ? c + 1 : 2 * n - c - 1;
    endfunction

    function automatic int carries_in(input wtab_t w, input int c);
        int cnt;
        cnt = 0;
        for (int p = 0; p < c; p++)
            if (int'(w[p]) > c - p) cnt++;
        return cnt;
    endfunction

    // nearest earlier column that sends a carry here, -1 if none
    function automatic int first_src(input wtab_t w, input int c);
        int fs;
        fs = -1;
        for (int k = c; k >= 1; k--)
            if (int'(w[c-k]) > k) fs = c - k;
        return fs;
    endfunction

    function automatic wtab_t col_widths(input int n);
        wtab_t w;
        int    b;
        w = '0;
        for (int c = 0; c < 2 * n; c++) begin
            b = bits_for(pp_count(n, c) + carries_in(w, c));
            if (b > 2 * n - c) b = 2 * n - c;
            w[c] = 4'(b);
        end
        return w;
    endfunction

    function automatic ltab_t line_tab(input int n);
        wtab_t w;
        ltab_t t;
        int    nxt, fs;
        w   = col_widths(n);
        t   = '0;
        nxt = 2 * n;
        for (int c = 0; c < 2 * n; c++) begin
            fs = first_src(w, c);
            for (int b = 0; b < int'(w[c]); b++) begin
                if (b == 0 && fs >= 0) t[c][0] = t[fs][c-fs];
                else begin
                    t[c][b] = 8'(nxt);
                    nxt++;
                end
            end
        end
        return t;
    endfunction

    function automatic int line_count(input int n);
        wtab_t w;
        int    nxt;
        w   = col_widths(n);
        nxt = 2 * n;
        for (int c = 0; c < 2 * n; c++)
            nxt += int'(w[c]) - ((first_src(w, c) >= 0) ? 1 : 0);
        return nxt;
    endfunction

    function automatic int sum_line(input int n, input int c);
        ltab_t t;
        t = line_tab(n);
        return int'(t[c][0]);
    endfunction

    // Walks columns, groups (partial products first, then extra carries)
    // and gates (widest first); returns gate g and the total count.
    function automatic gate_t gate_at(input int n, input int g);
        wtab_t           w;
        ltab_t           t;
        gate_t           r;
        logic [MAXL-1:0] base;
        int              cnt, fs, m, gw, tb, j, p;
        bit              used;
        w   = col_widths(n);
        t   = line_tab(n);
        r   = '0;
        cnt = 0;
        for (int c = 0; c < 2 * n; c++) begin
            fs = first_src(w, c);
            m  = (fs >= 0) ? 1 : 0;
            for (int u = 0; u < n + c; u++) begin
                base = '0;
                used = 1'b0;
                if (u < n) begin
                    j = c - u;
                    if (j >= 0 && j < n) begin
                        base[u]     = 1'b1;
                        base[n + j] = 1'b1;
                        used        = 1'b1;
                    end
                end else begin
                    p = c - (u - n + 1);
                    if (p >= 0 && p != fs && int'(w[p]) > u - n + 1) begin
                        base[t[p][u-n+1]] = 1'b1;
                        used              = 1'b1;
                    end
                end
                if (used) begin
                    m++;
                    gw = bits_for(m);
                    if (gw > int'(w[c])) gw = int'(w[c]);
                    for (int q = 0; q < gw; q++) begin
                        tb = gw - 1 - q;
                        if (cnt == g) begin
                            r.tgt = t[c][tb];
                            r.ctl = base;
                            for (int e = 0; e < tb; e++) r.ctl[t[c][e]] = 1'b1;
                        end
                        cnt++;
                    end
                end
            end
        end
        r.total = 16'(cnt);
        return r;
    endfunction

    function automatic int gate_count(input int n);
        gate_t x;
        x = gate_at(n, 0);
        return int'(x.total);
    endfunction

endpackage

// File: rtl/tof_stage.sv
module tof_stage #(
    parameter int            NL       = 8,
    parameter int            FWD_TGT  = 0,
    parameter logic [NL-1:0] FWD_MASK = '0,
    parameter int            REV_TGT  = 0,
    parameter logic [NL-1:0] REV_MASK = '0
) (
    input  logic          backward,
    input  logic [NL-1:0] d,
    output logic [NL-1:0] q
);

    always_comb begin
        q = d;
        if (backward) begin
            if (&(d | ~REV_MASK)) q[REV_TGT] = ~d[REV_TGT];
        end else begin
            if (&(d | ~FWD_MASK)) q[FWD_TGT] = ~d[FWD_TGT];
        end
    end

endmodule

// File: rtl/tof_cascade.sv
module tof_cascade
    import tofmul_pkg::*;
#(
    parameter int N  = 4,
    parameter int NL = line_count(N),
    parameter int NG = gate_count(N)
) (
    input  logic          backward,
    input  logic [NL-1:0] din,
    output logic [NL-1:0] dout
);

    logic [NL-1:0] chain [NG+1];

    assign chain[0] = din;

    for (genvar s = 0; s < NG; s++) begin : g_gate
        localparam gate_t GF = gate_at(N, s);
        localparam gate_t GR = gate_at(N, NG - 1 - s);
        tof_stage #(
            .NL      (NL),
            .FWD_TGT (int'(GF.tgt)),
            .FWD_MASK(GF.ctl[NL-1:0]),
            .REV_TGT (int'(GR.tgt)),
            .REV_MASK(GR.ctl[NL-1:0])
        ) u_stage (
            .backward(backward),
            .d       (chain[s]),
            .q       (chain[s+1])
        );
    end

    assign dout = chain[NG];

endmodule

// File: rtl/tof_col_multiplier.sv
module tof_col_multiplier
    import tofmul_pkg::*;
#(
    parameter  int N  = 4,
    localparam int NL = line_count(N),
    localparam int PW = 2 * N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_backward,
    input  logic [NL-1:0] line_in,
    output logic [NL-1:0] line_out,
    output logic [PW-1:0] product
);

    localparam int NG = gate_count(N);

    typedef struct packed {
        logic [NL-1:0] lines;
    } state_t;

    state_t        st_d, st_q;
    logic [NL-1:0] casc_out;

    tof_cascade #(.N(N), .NL(NL), .NG(NG)) u_cascade (
        .backward(run_backward),
        .din     (line_in),
        .dout    (casc_out)
    );

    always_comb begin
        st_d       = st_q;
        st_d.lines = casc_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_out = st_q.lines;

    for (genvar c = 0; c < PW; c++) begin : g_prod
        localparam int SL = sum_line(N, c);
        assign product[c] = st_q.lines[SL];
    end

endmodule

// File: rtl/tof_col_multiplier_chk.sv
module tof_col_multiplier_chk #(
    parameter int N  = 4,
    parameter int NL = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_backward,
    input logic [NL-1:0]     line_in,
    input logic [NL-1:0]     line_out,
    input logic [2*N-1:0]    product
);

    localparam int PW = 2 * N;

    logic [PW-1:0] a_ext, b_ext, ab;
    logic          clean_fwd, zero_op;

    assign a_ext     = PW'(line_in[N-1:0]);
    assign b_ext     = PW'(line_in[PW-1:N]);
    assign ab        = a_ext * b_ext;
    assign clean_fwd = !run_backward && (line_in[NL-1:PW] == '0);
    assign zero_op   = (a_ext == '0) || (b_ext == '0);

    // R1: value present at release is the reset value
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_out == '0 && product == '0));

    // R4: operand lines pass through unchanged
    assert_operand_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> line_out[PW-1:0] == $past(line_in[PW-1:0]));

    // R3: forward product with clean ancillas
    assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clean_fwd)) |-> product == $past(ab));

    // R6: zero operand leaves ancillas untouched
    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clean_fwd) && $past(zero_op)) |-> line_out[NL-1:PW] == '0);

endmodule

bind tof_col_multiplier tof_col_multiplier_chk #(.N(N), .NL(NL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_backward(run_backward),
    .line_in     (line_in),
    .line_out    (line_out),
    .product     (product)
);

// File: tb/tof_col_multiplier_test.sv
module tof_col_multiplier_test;

    localparam int NL2 = tofmul_pkg::line_count(2);
    localparam int NL4 = tofmul_pkg::line_count(4);
    localparam int NL8 = tofmul_pkg::line_count(8);

    // table for N=8: a[31:24] b[23:16] expected product[15:0]
    localparam logic [31:0] VEC8 [8] = '{
        {8'd255, 8'd255, 16'd65025},
        {8'd0,   8'd200, 16'd0},
        {8'd1,   8'd1,   16'd1},
        {8'd128, 8'd2,   16'd256},
        {8'd170, 8'd85,  16'd14450},
        {8'd13,  8'd11,  16'd143},
        {8'd255, 8'd1,   16'd255},
        {8'd100, 8'd100, 16'd10000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bw = 1'b0;
    logic [NL2-1:0] in2 = '0, out2, keep2;
    logic [NL4-1:0] in4 = '0, out4, keep4;
    logic [NL8-1:0] in8 = '0, out8, keep8;
    logic [3:0]  p2;
    logic [7:0]  p4;
    logic [15:0] p8;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tof_col_multiplier #(.N(4)) uut (
        .clk(clk), .rst_n(rst_n), .run_backward(bw),
        .line_in(in4), .line_out(out4), .product(p4));
    tof_col_multiplier #(.N(2)) uut_n2 (
        .clk(clk), .rst_n(rst_n), .run_backward(bw),
        .line_in(in2), .line_out(out2), .product(p2));
    tof_col_multiplier #(.N(8)) uut_n8 (
        .clk(clk), .rst_n(rst_n), .run_backward(bw),
        .line_in(in8), .line_out(out8), .product(p8));

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        // R1: reset wins over nonzero inputs
        in4 = NL4'(8'hFF);
        in2 = NL2'(4'hF);
        in8 = NL8'(16'hFFFF);
        repeat (3) @(negedge clk);
        chk(out4 == '0 && p4 == '0, "R1", 64'(out4), 64'd0);
        chk(out2 == '0 && p2 == '0, "R1", 64'(out2), 64'd0);
        chk(out8 == '0 && p8 == '0, "R1", 64'(out8), 64'd0);

        // R7: line vector widths
        chk($bits(out2) == 8, "R7", 64'($bits(out2)), 64'd8);
        chk($bits(out4) == 20, "R7", 64'($bits(out4)), 64'd20);

        rst_n = 1'b1;

        // R2: new input not visible before the edge, visible after it
        in4 = NL4'({4'd3, 4'd5});
        #1;
        chk(out4 == '0, "R2", 64'(out4), 64'd0);
        @(negedge clk);
        chk(p4 == 8'd15, "R2", 64'(p4), 64'd15);
        in4 = NL4'({4'd7, 4'd7});
        #1;
        chk(p4 == 8'd15, "R2", 64'(p4), 64'd15);
        @(negedge clk);
        chk(p4 == 8'd49, "R2", 64'(p4), 64'd49);

        // N=4 exhaustive: R3 R4 R6, then round trip R5
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                bw  = 1'b0;
                in4 = NL4'({4'(b), 4'(a)});
                keep4 = in4;
                @(negedge clk);
                chk(p4 == 8'(a * b), "R3", 64'(p4), 64'(a * b));
                chk(out4[7:0] == keep4[7:0], "R4", 64'(out4[7:0]), 64'(keep4[7:0]));
                if (a == 0 || b == 0)
                    chk(out4[NL4-1:8] == '0, "R6", 64'(out4[NL4-1:8]), 64'd0);
                bw  = 1'b1;
                in4 = out4;
                @(negedge clk);
                chk(out4 == keep4, "R5", 64'(out4), 64'(keep4));
            end
        end

        // N=2 exhaustive
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                bw  = 1'b0;
                in2 = NL2'({2'(b), 2'(a)});
                keep2 = in2;
                @(negedge clk);
                chk(p2 == 4'(a * b), "R3", 64'(p2), 64'(a * b));
                bw  = 1'b1;
                in2 = out2;
                @(negedge clk);
                chk(out2 == keep2, "R5", 64'(out2), 64'(keep2));
            end
        end

        // N=8 vector table
        for (int v = 0; v < 8; v++) begin
            bw  = 1'b0;
            in8 = NL8'({VEC8[v][23:16], VEC8[v][31:24]});
            keep8 = in8;
            @(negedge clk);
            chk(p8 == VEC8[v][15:0], "R3", 64'(p8), 64'(VEC8[v][15:0]));
            chk(out8[15:0] == keep8[15:0], "R4", 64'(out8[15:0]), 64'(keep8[15:0]));
            bw  = 1'b1;
            in8 = out8;
            @(negedge clk);
            chk(out8 == keep8, "R5", 64'(out8), 64'(keep8));
        end

        // R4 in backward mode: operand lines kept with dirty ancillas
        bw  = 1'b1;
        in4 = {{(NL4-8){1'b1}}, 8'hA5};
        @(negedge clk);
        chk(out4[7:0] == 8'hA5, "R4", 64'(out4[7:0]), 64'hA5);

        // R1 again: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk(out4 == '0 && p8 == '0, "R1", 64'(out4), 64'd0);

        finish_run();
    end

endmodule